// File: doc/BRIEF.md
# Colour Lookup Table Loader

This block holds a 256-entry colour lookup table for a display pipeline. Each entry has an 8-bit red, green and blue part. Software fills the table through a small write-only register window. It first writes a pointer register that selects an entry. It then writes three times to a data register, which stores red, then green, then blue into that entry.

The scanout logic reads the table through a separate port. It presents a pixel code and gets the packed colour one clock later. Reads of the register window always return zero. The table is kept in memories that can be inferred as block RAM. A per-entry, per-component mark records whether each part has been written since reset. Until a part is written, the lookup returns its reset value.

Top module: `clut_loader`

## Requirements
- R1: A write with bus_addr[3:2] = 0 loads the entry pointer from bus_wdata[31:24] and returns the component sequencer to the red phase. bus_addr[1:0] and bus_wdata[23:0] are ignored.
- R2: A write with bus_addr[3:2] = 1 stores bus_wdata[31:24] into one component of the entry at the pointer. The first such write goes to red, the second to green and the third to blue, and the phase advances after each write.
- R3: After the blue write the phase goes back to red and the pointer does not change, so a further triple overwrites the same entry.
- R4: A write to bus_addr[3:2] = 2 or 3 changes nothing. A cycle with bus_valid low, or with bus_we low, also changes nothing. "Nothing" covers the table, the pointer and the phase.
- R5: After reset every entry reads 0x000000 except entry 255, which reads 0xFFFFFF. The pointer and the phase are cleared, so the first data write goes to red of entry 0.
- R6: bus_rdata is zero at all times, including during read cycles.
- R7: lk_rgb shows the entry selected by the lk_idx value sampled at the previous rising edge. The packing is {red[23:16], green[15:8], blue[7:0]}.
- R8: When a component write and a lookup of the same entry fall in the same cycle, the lookup returns the value held before the write. The new value is visible from the next lookup.
- R9: A pointer write in the middle of a triple restarts the sequence at red for the new entry. Components already written to the old entry keep their new values, and the components not reached keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write enable for the access |
| bus_addr | input | 4 | Byte address within the window |
| bus_wdata | input | 32 | Write data; only bits [31:24] are used |
| bus_rdata | output | 32 | Read data; always zero |
| lk_idx | input | 8 | Pixel code to look up |
| lk_rgb | output | 24 | Colour of the entry, one clock after lk_idx |

## Verification
A wrong phase register shows up on the very next lookup of the entry being loaded: the colour byte appears in the wrong position of lk_rgb. A wrong pointer shows up as the colour landing in an entry other than the one probed. A written mark that is lost or set by mistake makes a lookup return the reset colour instead of the stored colour, or the reverse. Entry 255 with only some components written is the sharpest probe for this. Every such fault becomes visible at lk_rgb one clock after the affected entry is presented, and the scoreboard compares each lookup in that cycle.

// File: rtl/clut_pkg.sv
package clut_pkg;

  // Sequencer phase: which colour part the next data write fills
  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;

  // Register selector carried in bus_addr[3:2]
  localparam logic [1:0] SEL_POINTER = 2'd0;
  localparam logic [1:0] SEL_DATA    = 2'd1;

  localparam int unsigned N_COMP = 3;

endpackage

// File: rtl/clut_wr_seq.sv
module clut_wr_seq
  import clut_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [N_COMP-1:0] wr_comp_en,
  output logic [COMP_W-1:0] wr_val
);

  localparam int unsigned SEL_LSB = 2;

  logic [1:0]       sel;
  logic             acc_wr;
  logic             ptr_wr;
  logic             dat_wr;
  logic [IDX_W-1:0] ptr_byte;
  logic [IDX_W-1:0] idx_q;
  phase_e           phase_q;

  assign sel      = bus_addr[SEL_LSB+1:SEL_LSB];
  assign acc_wr   = bus_valid && bus_we;
  assign ptr_wr   = acc_wr && (sel == SEL_POINTER);
  assign dat_wr   = acc_wr && (sel == SEL_DATA);
  assign ptr_byte = bus_wdata[DATA_W-1 -: IDX_W];
  assign wr_val   = bus_wdata[DATA_W-1 -: COMP_W];
  assign wr_idx   = idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      phase_q <= PH_RED;
    end else if (ptr_wr) begin
      idx_q   <= ptr_byte;
      phase_q <= PH_RED;
    end else if (dat_wr) begin
      case (phase_q)
        PH_RED:  phase_q <= PH_GRN;
        PH_GRN:  phase_q <= PH_BLU;
        default: phase_q <= PH_RED;
      endcase
    end
  end

  always_comb begin
    wr_comp_en = '0;
    for (int c = 0; c < int'(N_COMP); c++) begin
      wr_comp_en[c] = dat_wr && (phase_q == phase_e'(c));
    end
  end

  assert_phase_legal_R2: assert property (@(posedge clk) disable iff (rst)
    phase_q != 2'd3);

  assert_pointer_load_R1: assert property (@(posedge clk) disable iff (rst)
    ptr_wr |=> (phase_q == PH_RED && idx_q == $past(ptr_byte)));

  assert_blue_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (dat_wr && phase_q == PH_BLU) |=> (phase_q == PH_RED && $stable(idx_q)));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !(ptr_wr || dat_wr) |=> ($stable(idx_q) && $stable(phase_q)));

endmodule

// File: rtl/clut_bank.sv
module clut_bank #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 8,
  parameter logic        TOP_ONES = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [COMP_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [COMP_W-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam logic [IDX_W-1:0] TOP_ENTRY = IDX_W'(DEPTH - 1);

  logic [COMP_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  written_q;
  logic [COMP_W-1:0] rd_q;
  logic              hit_q;
  logic              top_q;

  // Read-before-write memory without reset, suitable for block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rd_q <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      written_q <= '0;
      hit_q     <= 1'b0;
      top_q     <= 1'b0;
    end else begin
      if (we) written_q[waddr] <= 1'b1;
      hit_q <= written_q[raddr];
      top_q <= (raddr == TOP_ENTRY);
    end
  end

  assign rdata = hit_q ? rd_q : ((top_q && TOP_ONES) ? '1 : '0);

  assert_mark_set_R2: assert property (@(posedge clk) disable iff (rst)
    we |=> written_q[$past(waddr)]);

endmodule

// File: rtl/clut_loader.sv
module clut_loader
  import clut_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_valid,
  input  logic                     bus_we,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  input  logic [IDX_W-1:0]         lk_idx,
  output logic [N_COMP*COMP_W-1:0] lk_rgb
);

  logic [IDX_W-1:0]  wr_idx;
  logic [N_COMP-1:0] wr_comp_en;
  logic [COMP_W-1:0] wr_val;

  assign bus_rdata = '0;

  clut_wr_seq #(
    .IDX_W(IDX_W), .COMP_W(COMP_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) seq_i (
    .clk(clk), .rst(rst),
    .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .wr_idx(wr_idx), .wr_comp_en(wr_comp_en), .wr_val(wr_val)
  );

  for (genvar c = 0; c < int'(N_COMP); c++) begin : g_lane
    logic [COMP_W-1:0] lane_rd;
    clut_bank #(
      .IDX_W(IDX_W), .COMP_W(COMP_W), .TOP_ONES(1'b1)
    ) bank_i (
      .clk(clk), .rst(rst),
      .we(wr_comp_en[c]), .waddr(wr_idx), .wdata(wr_val),
      .raddr(lk_idx), .rdata(lane_rd)
    );
    // lane 0 (red) occupies the most significant byte
    assign lk_rgb[(int'(N_COMP) - c)*COMP_W-1 -: COMP_W] = lane_rd;
  end

  assert_one_lane_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_comp_en));

endmodule

// File: tb/clut_loader_tb_top.sv
`timescale 1ns/1ps
module clut_loader_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  lk_idx = '0;
  logic [23:0] lk_rgb;

  always #10 clk = ~clk;

  clut_loader dut_i (
    .clk(clk), .rst(rst),
    .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lk_idx(lk_idx), .lk_rgb(lk_rgb)
  );

  typedef struct {
    logic [23:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] mr [256];
  logic [7:0] mg [256];
  logic [7:0] mb [256];
  logic [7:0] midx;
  int         mph;

  function automatic void model_reset();
    for (int i = 0; i < 256; i++) begin
      mr[i] = 8'h00; mg[i] = 8'h00; mb[i] = 8'h00;
    end
    mr[255] = 8'hFF; mg[255] = 8'hFF; mb[255] = 8'hFF;
    midx = 8'h00;
    mph = 0;
  endfunction

  function automatic void model_write(logic [3:0] a, logic [31:0] d);
    if (a[3:2] == 2'd0) begin
      midx = d[31:24];
      mph = 0;
    end else if (a[3:2] == 2'd1) begin
      case (mph)
        0: mr[midx] = d[31:24];
        1: mg[midx] = d[31:24];
        default: mb[midx] = d[31:24];
      endcase
      mph = (mph == 2) ? 0 : mph + 1;
    end
  endfunction

  // Driver: one cycle of bus activity plus an optional lookup probe
  task automatic step(input logic v, input logic w, input logic [3:0] a,
                      input logic [31:0] d, input logic pr,
                      input logic [7:0] pi, input string tag);
    if (pr) begin
      item_t it;
      it.exp = {mr[pi], mg[pi], mb[pi]};
      it.tag = tag;
      sb.push_back(it);
    end
    if (v && w) model_write(a, d);
    bus_valid = v; bus_we = w; bus_addr = a; bus_wdata = d;
    lk_idx = pr ? pi : 8'h00;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    step(1'b1, 1'b1, a, d, 1'b0, 8'h00, "");
  endtask

  task automatic probe(input logic [7:0] pi, input string tag);
    step(1'b0, 1'b0, 4'h0, 32'h0, 1'b1, pi, tag);
  endtask

  // Monitor: compare mid-way through the high phase
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #5;
      if (!rst && bus_valid && !bus_we) begin
        n_run++;
        if (bus_rdata !== 32'h0) begin
          n_fail++;
          $display("FAIL R6: bus_rdata actual %h expected %h", bus_rdata, 32'h0);
        end
      end
      if (sb.size() > 0) begin
        it = sb.pop_front();
        n_run++;
        if (lk_rgb !== it.exp) begin
          n_fail++;
          $display("FAIL %s: lk_rgb actual %h expected %h", it.tag, lk_rgb, it.exp);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R5: reset contents
    probe(8'h00, "R5 entry0");
    probe(8'hFF, "R5 entry255 white");
    probe(8'h80, "R5 entry128");
    probe(8'hFE, "R5 entry254");
    // R5: pointer and phase cleared -> red of entry 0
    wr(4'h4, 32'h5A00_0000);
    probe(8'h00, "R5 first data to red of entry0");

    // R6: read cycles return zero
    step(1'b1, 1'b0, 4'h0, 32'hFFFF_FFFF, 1'b0, 8'h00, "");
    step(1'b1, 1'b0, 4'h4, 32'hFFFF_FFFF, 1'b0, 8'h00, "");

    // R1 / R2: pointer with junk low bits, full triple
    wr(4'h0, 32'h10AB_CDEF);
    wr(4'h4, 32'h1100_00FF);
    wr(4'h4, 32'h2212_3456);
    wr(4'h4, 32'h33FF_FFFF);
    probe(8'h10, "R2 triple to entry 0x10");

    // R3: second triple without pointer write overwrites same entry
    wr(4'h4, 32'h4400_0000);
    wr(4'h4, 32'h5500_0000);
    wr(4'h4, 32'h6600_0000);
    probe(8'h10, "R3 overwrite same entry");
    probe(8'h11, "R3 no auto increment");

    // R9: pointer write mid-triple
    wr(4'h0, 32'h2000_0000);
    wr(4'h4, 32'hAA00_0000);
    wr(4'h0, 32'h3000_0000);
    wr(4'h7, 32'hBB00_0000);     // R1: addr[1:0] ignored
    probe(8'h20, "R9 partial entry 0x20");
    probe(8'h30, "R9 restart at red for 0x30");

    // R4: ignored accesses, then finish the triple of 0x30
    wr(4'h8, 32'h0100_0000);
    wr(4'hC, 32'h0200_0000);
    step(1'b0, 1'b1, 4'h4, 32'h0300_0000, 1'b0, 8'h00, "");
    step(1'b1, 1'b0, 4'h0, 32'h0400_0000, 1'b0, 8'h00, "");
    probe(8'h30, "R4 entry 0x30 untouched");
    wr(4'h4, 32'hCC00_0000);
    wr(4'h4, 32'hDD00_0000);
    probe(8'h30, "R4 phase and pointer kept");
    probe(8'h01, "R4 entry1 untouched");

    // R8: same-cycle write and lookup of entry 255
    wr(4'h0, 32'hFF00_0000);
    step(1'b1, 1'b1, 4'h4, 32'h0100_0000, 1'b1, 8'hFF, "R8 old value on collision");
    probe(8'hFF, "R8 new red, green/blue stay white");

    // R7: back-to-back lookups, one cycle latency each
    probe(8'h10, "R7 stream 0x10");
    probe(8'h00, "R7 stream 0x00");
    probe(8'h30, "R7 stream 0x30");
    probe(8'h20, "R7 stream 0x20");

    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      n_run++;
      n_fail++;
      $display("FAIL R7: pending lookups actual %0d expected 0", sb.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule